// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes one word at a time from a transmit holding stage that has a valid/ready handshake. It shifts the word out on MOSI while it shifts a word in from MISO, and it hands the received word back with a one-cycle valid strobe. SCLK is made from the system clock by a 16-bit baud divider. The word length, clock polarity, sampling phase, idle clock level, bit order, internal loopback and separate transmit and receive gates all come from one control word.

Words run back to back. A second word can be accepted into the holding stage while the first is still in the shift register. The busy flag covers both stages, so it stays high until the last SCLK edge of the last word has been produced. The control word and the baud value are captured when a word is loaded into the shift register, so a change to either one only affects later words.

Top module: `spi_eng_top`

## Requirements
- R1: Control word bits: [4:0] word length minus one, [5] polarity, [6] phase, [7] idle level, [8] MSB-first, [9] loopback, [10] transmit off, [11] receive off. The control word and the baud value are captured when a word enters the shift register. Changing either one while the word is shifting has no effect on that word.
- R2: Every SCLK half period inside a word lasts exactly baud+1 system clocks. A baud value of 0 gives half the system clock rate.
- R3: A word of N bits (N = field+1, from 2 to 32) produces exactly 2N SCLK transitions.
- R4: With the phase bit at 1, both ends sample on the leading (even-numbered) SCLK edges and change data on the trailing edges. With the phase bit at 0, data changes on the leading edges and is sampled on the trailing edges.
- R5: During a word, SCLK starts at the polarity bit, so the first transition moves away from it.
- R6: When no word is shifting, SCLK equals the live idle-level bit, even when that bit differs from the polarity bit.
- R7: With MSB-first at 1, bit N-1 goes first on MOSI and the first MISO bit lands in bit N-1. With MSB-first at 0, bit 0 goes first in both directions. Transmit bits above N-1 are ignored.
- R8: With loopback at 1, the receiver takes its bits from MOSI and ignores MISO.
- R9: With transmit off, MOSI stays 0 for the whole word. SCLK still runs, and each word still needs a transmit handshake to start.
- R10: With receive off, no receive valid strobe is produced for the word.
- R11: The transmit holding stage accepts a new word while the previous word is still shifting. Busy stays high from acceptance until the final SCLK edge of the last word.
- R12: A received word is given on rx_data with rx_valid high for one cycle. It is right-aligned and has zeros above bit N-1.
- R13: After reset, busy and rx_valid are low, tx_ready is high, and SCLK is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 12 | Control word (see R1) |
| baud_i | input | 16 | Half-period divider value |
| tx_data_i | input | 32 | Word to transmit |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Holding stage empty |
| miso_i | input | 1 | Serial data from slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to slave |
| rx_data_o | output | 32 | Received word, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data |
| busy_o | output | 1 | Holding stage or shift register occupied |

## Verification
The bench runs a slave model that samples MOSI and drives MISO according to the configured phase. Its vectors cover all four clock modes, both bit orders, and lengths of 2, 5, 8, 16 and 32 bits. A phase bit that is not inverted shows up as bits that are off by one edge. A wrong bit order shows up as a reversed word. A received word that is not right-aligned shows up as stray high bits when N is short. Directed tests change the control word in the middle of a word: a design that does not capture its configuration would change length or order part-way through. An idle level that differs from the polarity catches a design that ties the two together. Transmit-off, receive-off and loopback with a hostile MISO each check at the pins that the gated path has no effect. A back-to-back push checks that busy does not drop while the shift register still holds the first word.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int DATA_W = 32;
    localparam int LEN_W  = $clog2(DATA_W);
    localparam int CNT_W  = LEN_W + 1;
    localparam int CTRL_W = LEN_W + 7;

    typedef struct packed {
        logic             rx_off;
        logic             tx_off;
        logic             loop;
        logic             msb_first;
        logic             idle_lvl;
        logic             ph_n;
        logic             pol;
        logic [LEN_W-1:0] len_m1;
    } eng_cfg_t;

    // index of the final SCLK edge of an N-bit word: 2N-1
    function automatic logic [CNT_W-1:0] final_edge(input logic [LEN_W-1:0] m1);
        return {m1, 1'b1};
    endfunction
endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BAUD_W-1:0] br_i,
    input  logic              run,
    output logic              tick
);
    logic [BAUD_W-1:0] br_q;
    logic [BAUD_W-1:0] cnt;

    assign tick = run && (cnt == br_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            br_q <= '0;
            cnt  <= '0;
        end else begin
            if (load)
                br_q <= br_i;
            if (!run || tick)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  eng_cfg_t          cfg_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              tick,
    input  logic              sin,
    output logic              active,
    output eng_cfg_t          cfg_q,
    output logic              mosi,
    output logic              sclk,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_done
);
    logic              phase;
    logic [CNT_W-1:0]  edge_cnt;
    logic [DATA_W-1:0] sr_tx;
    logic [DATA_W-1:0] sr_rx;
    logic              smp_edge;
    logic              last_edge;
    logic              tx_bit;
    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] tx_next;

    always_comb begin
        smp_edge  = (~edge_cnt[0]) == cfg_q.ph_n;
        last_edge = edge_cnt == final_edge(cfg_q.len_m1);
        tx_bit    = cfg_q.msb_first ? sr_tx[cfg_q.len_m1] : sr_tx[0];
        if (cfg_q.msb_first) begin
            rx_next = {sr_rx[DATA_W-2:0], sin};
            tx_next = {sr_tx[DATA_W-2:0], 1'b0};
        end else begin
            rx_next = (sr_rx >> 1) | (DATA_W'(sin) << cfg_q.len_m1);
            tx_next = {1'b0, sr_tx[DATA_W-1:1]};
        end
    end

    assign sclk    = active ? (cfg_q.pol ^ phase) : cfg_i.idle_lvl;
    assign mosi    = active && !cfg_q.tx_off && tx_bit;
    assign rx_word = sr_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            phase    <= 1'b0;
            edge_cnt <= '0;
            sr_tx    <= '0;
            sr_rx    <= '0;
            cfg_q    <= '0;
            rx_done  <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    cfg_q    <= cfg_i;
                    sr_tx    <= word_i;
                    sr_rx    <= '0;
                    edge_cnt <= '0;
                    phase    <= 1'b0;
                end
            end else if (tick) begin
                phase    <= ~phase;
                edge_cnt <= edge_cnt + 1'b1;
                if (smp_edge && !cfg_q.rx_off)
                    sr_rx <= rx_next;
                if (!smp_edge && edge_cnt != '0)
                    sr_tx <= tx_next;
                if (last_edge) begin
                    active  <= 1'b0;
                    rx_done <= !cfg_q.rx_off;
                end
            end
        end
    end
endmodule

// File: rtl/spi_eng_top.sv
module spi_eng_top
    import spi_eng_pkg::*;
#(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [BAUD_W-1:0] baud_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              busy_o
);
    logic              hold_v;
    logic [DATA_W-1:0] hold_d;
    logic              active;
    logic              start;
    logic              tick;
    logic              sin;
    eng_cfg_t          cfg_q;
    eng_cfg_t          cfg_live;

    assign cfg_live   = eng_cfg_t'(ctrl_i);
    assign tx_ready_o = !hold_v;
    assign start      = hold_v && !active;
    assign busy_o     = hold_v || active;
    assign sin        = cfg_q.loop ? mosi_o : miso_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_d <= '0;
        end else if (tx_valid_i && !hold_v) begin
            hold_v <= 1'b1;
            hold_d <= tx_data_i;
        end else if (start) begin
            hold_v <= 1'b0;
        end
    end

    spi_eng_baud #(.BAUD_W(BAUD_W)) baud_i0 (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .br_i (baud_i),
        .run  (active),
        .tick (tick)
    );

    spi_eng_shifter shf_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cfg_i   (cfg_live),
        .word_i  (hold_d),
        .tick    (tick),
        .sin     (sin),
        .active  (active),
        .cfg_q   (cfg_q),
        .mosi    (mosi_o),
        .sclk    (sclk_o),
        .rx_word (rx_data_o),
        .rx_done (rx_valid_o)
    );
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk
    import spi_eng_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] ctrl_i,
    input logic              busy_o,
    input logic              sclk_o,
    input logic              mosi_o,
    input logic              tx_valid_i,
    input logic              tx_ready_o,
    input logic              rx_valid_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              active,
    input eng_cfg_t          cfg_q
);
    eng_cfg_t live;
    assign live = eng_cfg_t'(ctrl_i);

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> sclk_o == live.idle_lvl);

    // R9
    tx_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (active && cfg_q.tx_off) |-> !mosi_o);

    // R10
    rx_off_silent_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> !cfg_q.rx_off);

    // R12
    rx_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> $past(active));

    // R12
    rx_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && cfg_q.len_m1 != '1) |-> ((rx_data_o >> (cfg_q.len_m1 + 1'b1)) == '0));

    // R11
    hold_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_i && tx_ready_o) |=> (!tx_ready_o && busy_o));

    // R1
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(cfg_q));
endmodule

bind spi_eng_top spi_eng_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .ctrl_i     (ctrl_i),
    .busy_o     (busy_o),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o),
    .active     (active),
    .cfg_q      (cfg_q)
);

// File: tb/spi_eng_top_tb.sv
`timescale 1ns/1ps
module spi_eng_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ctrl_i = '0;
    logic [15:0] baud_i = '0;
    logic [31:0] tx_data_i = '0;
    logic        tx_valid_i = 1'b0;
    logic        tx_ready_o;
    logic        miso_i = 1'b0;
    logic        sclk_o, mosi_o, rx_valid_o, busy_o;
    logic [31:0] rx_data_o;

    always #10 clk = ~clk;

    spi_eng_top dut_i (
        .clk(clk), .rst(rst), .ctrl_i(ctrl_i), .baud_i(baud_i),
        .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
        .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .busy_o(busy_o)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic [5:0]  n;
        logic        pol;
        logic        cpha;
        logic        msb;
        logic [15:0] br;
        logic [31:0] tx;
        logic [31:0] slv;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{6'd8,  1'b0, 1'b0, 1'b1, 16'd0, 32'h000000A5, 32'h0000003C},
        '{6'd8,  1'b0, 1'b1, 1'b0, 16'd1, 32'h00000096, 32'h0000000F},
        '{6'd16, 1'b1, 1'b0, 1'b1, 16'd2, 32'h0000BEEF, 32'h00001234},
        '{6'd32, 1'b1, 1'b1, 1'b0, 16'd0, 32'hDEADBEEF, 32'h0BADF00D},
        '{6'd2,  1'b0, 1'b0, 1'b0, 16'd3, 32'h00000002, 32'h00000001},
        '{6'd5,  1'b1, 1'b1, 1'b1, 16'd0, 32'h00000013, 32'h0000000A}
    };

    // monitor state
    bit          mon_en = 0;
    int          mon_n, mon_br;
    bit          mon_msb, mon_cpha1, mon_pol;
    logic [31:0] mon_slv, cap;
    int          tog, samp, per_err, busy_err, pol_err, mosi_hi, rxv_cnt;
    longint      cyc = 0, last_cyc = 0;
    logic        prev_sclk = 1'b0;
    logic [31:0] rx_last = '0;

    always @(negedge clk) begin
        cyc++;
        if (rx_valid_o) begin
            rxv_cnt++;
            rx_last = rx_data_o;
        end
        if (mon_en) begin
            if (busy_o && mosi_o) mosi_hi++;
            if (sclk_o !== prev_sclk) begin
                if (tog == 0 && prev_sclk !== mon_pol) pol_err++;
                if (tog > 0 && (cyc - last_cyc) != longint'(mon_br + 1)) per_err++;
                if (tog < 2*mon_n - 1 && !busy_o) busy_err++;
                last_cyc = cyc;
                if (((tog % 2) == 0) != mon_cpha1) begin
                    cap[mon_msb ? mon_n-1-samp : samp] = mosi_o;
                    samp++;
                    if (samp < mon_n) miso_i = mon_slv[mon_msb ? mon_n-1-samp : samp];
                end
                tog++;
            end
        end
        prev_sclk = sclk_o;
    end

    function automatic logic [11:0] mk_ctrl(int n, bit pol, bit cpha, bit msb, bit idle,
                                            bit loop, bit txoff, bit rxoff);
        logic [4:0] m1 = 5'(n - 1);
        return {rxoff, txoff, loop, msb, idle, ~cpha, pol, m1};
    endfunction

    function automatic logic [31:0] mask_of(int n);
        return (n >= 32) ? 32'hFFFFFFFF : ((32'h1 << n) - 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic arm(input int n, input bit pol, input bit cpha, input bit msb,
                       input int br, input logic [31:0] slv, input bit en);
        mon_n = n; mon_pol = pol; mon_cpha1 = cpha; mon_msb = msb; mon_br = br;
        mon_slv = slv; cap = '0; tog = 0; samp = 0; per_err = 0; busy_err = 0;
        pol_err = 0; mosi_hi = 0; rxv_cnt = 0;
        miso_i = slv[msb ? n-1 : 0];
        mon_en = en;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk);
        while (!tx_ready_o) @(negedge clk);
        tx_data_i  = d;
        tx_valid_i = 1'b1;
        @(negedge clk);
        tx_valid_i = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy_o && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(!busy_o, "R13 busy", 32'(busy_o), 0);
        chk(tx_ready_o, "R13 tx_ready", 32'(tx_ready_o), 1);
        chk(!rx_valid_o, "R13 rx_valid", 32'(rx_valid_o), 0);
        chk(sclk_o == 1'b0, "R13 sclk idle", 32'(sclk_o), 0);

        // vector table: R2 R3 R4 R5 R7 R12 R11
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            int n = int'(t.n);
            ctrl_i = mk_ctrl(n, t.pol, t.cpha, t.msb, t.pol, 1'b0, 1'b0, 1'b0);
            baud_i = t.br;
            repeat (2) @(negedge clk);
            arm(n, t.pol, t.cpha, t.msb, int'(t.br), t.slv, 1'b1);
            push(t.tx | ~mask_of(n));
            wait_idle();
            mon_en = 0;
            chk(rx_last == t.slv, "R12 R7 R4 rx word", rx_last, t.slv);
            chk(cap == t.tx, "R7 R4 mosi word", cap, t.tx);
            chk(per_err == 0, "R2 half period", 32'(per_err), 0);
            chk(tog == 2*n, "R3 edge count", 32'(tog), 32'(2*n));
            chk(busy_err == 0, "R11 busy held", 32'(busy_err), 0);
            chk(pol_err == 0, "R5 start level", 32'(pol_err), 0);
            chk(rxv_cnt == 1, "R12 one strobe", 32'(rxv_cnt), 1);
        end

        // R1: change control and baud mid-word
        ctrl_i = mk_ctrl(8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        baud_i = 16'd1;
        repeat (2) @(negedge clk);
        arm(8, 1'b0, 1'b0, 1'b1, 1, 32'h000000C3, 1'b1);
        push(32'h0000005A);
        repeat (3) @(negedge clk);
        ctrl_i = mk_ctrl(16, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        baud_i = 16'd5;
        wait_idle();
        mon_en = 0;
        chk(rx_last == 32'hC3, "R1 rx unaffected", rx_last, 32'hC3);
        chk(cap == 32'h5A, "R1 mosi unaffected", cap, 32'h5A);
        chk(tog == 16 && per_err == 0, "R1 length/baud frozen", 32'(tog), 16);

        // R6: idle level differs from polarity; R8 loopback
        ctrl_i = mk_ctrl(8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        baud_i = 16'd0;
        repeat (2) @(negedge clk);
        chk(sclk_o == 1'b1, "R6 idle before", 32'(sclk_o), 1);
        arm(8, 1'b0, 1'b0, 1'b1, 0, 32'hFF, 1'b0);
        miso_i = 1'b1;
        push(32'h0000005A);
        wait_idle();
        chk(sclk_o == 1'b1, "R6 idle after", 32'(sclk_o), 1);
        chk(rx_last == 32'h5A, "R8 loopback rx", rx_last, 32'h5A);
        ctrl_i = mk_ctrl(8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk(sclk_o == 1'b0, "R6 live idle", 32'(sclk_o), 0);

        // R9: transmit off with loopback
        ctrl_i = mk_ctrl(8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        arm(8, 1'b0, 1'b0, 1'b1, 0, 32'hFF, 1'b1);
        push(32'hFFFFFFFF);
        wait_idle();
        mon_en = 0;
        chk(mosi_hi == 0, "R9 mosi quiet", 32'(mosi_hi), 0);
        chk(tog == 16, "R9 clocks run", 32'(tog), 16);
        chk(rx_last == 32'h0, "R9 loop rx zero", rx_last, 0);

        // R10: receive off
        ctrl_i = mk_ctrl(8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        arm(8, 1'b0, 1'b0, 1'b1, 0, 32'hAA, 1'b1);
        push(32'h00000081);
        wait_idle();
        mon_en = 0;
        chk(rxv_cnt == 0, "R10 no strobe", 32'(rxv_cnt), 0);
        chk(cap == 32'h81, "R10 tx still sent", cap, 32'h81);

        // R11: back-to-back words through the holding stage
        ctrl_i = mk_ctrl(8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        baud_i = 16'd2;
        repeat (2) @(negedge clk);
        arm(8, 1'b0, 1'b0, 1'b0, 2, 32'h0, 1'b0);
        push(32'h00000011);
        @(negedge clk);
        chk(tx_ready_o && busy_o, "R11 ready while shifting", {30'd0, tx_ready_o, busy_o}, 3);
        push(32'h00000022);
        @(negedge clk);
        chk(rxv_cnt == 0 && busy_o, "R11 second held", 32'(rxv_cnt), 0);
        wait_idle();
        chk(rxv_cnt == 2, "R11 two words", 32'(rxv_cnt), 2);
        chk(rx_last == 32'h22, "R11 second word", rx_last, 32'h22);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule